// File: doc/BRIEF.md
# Differential Torque Error Integral Monitor

This block watches a drivetrain with two wheels driven by separate motors. Each wheel has a signed commanded torque and a signed measured torque. The monitor works out the error term for each wheel. It then takes the magnitude of the difference between the two error terms and clips it to the largest error the monitor has to handle, 5100 Nm. On every sample strobe, nominally one every 5 ms, it takes a tolerated allowance off that magnitude, adds the result to a running torque-time sum, and never lets the sum fall below zero. Brief transient errors therefore decay away, while a sustained imbalance builds toward a trip.

When the sum reaches the threshold parameter, the block latches a fault flag and a request for the active-short-circuit safe state. One cycle after the trip, the sum stops updating. The threshold is given in Nm·tick units. The primary instance uses 25500, which is 5100 Nm held for 25 ms. A diverse secondary instance uses the same logic with 45900, which is 45 ms at full error.

A stall watchdog covers a strobe source that has stopped. If no strobe arrives for two nominal sample periods, it latches its own flag and also raises the safe-state request. Only the asynchronous reset or the synchronous clear input releases any latched state.

Top module: `torque_err_monitor`

## Requirements
- R1: The per-strobe error magnitude is |(cmd_l_i - meas_l_i) - (cmd_r_i - meas_r_i)|. All four inputs are signed 16-bit whole Nm, and the result is clipped at MAX_ERR (5100).
- R2: On a cycle with strobe_i high, integ_o becomes max(0, integ_o + magnitude - ALLOW) at that clock edge, with ALLOW = 255 by default. With strobe_i low, integ_o is unchanged.
- R3: integ_o never exceeds THRESH + MAX_ERR, so it cannot wrap.
- R4: fault_o and safe_req_o rise on the clock edge after the edge at which integ_o first reaches or exceeds THRESH (default 25500), and not before that edge.
- R5: fault_o, wdog_o and safe_req_o are sticky. Once set, they stay set until clr_i or rst_ni.
- R6: integ_o holds its value while safe_req_o is high, even when strobes arrive.
- R7: wdog_o and safe_req_o rise on the edge that completes 2*TICK_CYCLES consecutive strobe-free cycles after the last strobe, clear or reset. Any strobe restarts that count.
- R8: A clock edge with clr_i high returns integ_o to 0, clears fault_o, wdog_o and safe_req_o, and restarts the stall count.
- R9: While rst_ni is low, integ_o is 0 and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of sum, flags and stall count |
| strobe_i | input | 1 | Sample strobe, one cycle wide per sample |
| cmd_l_i | input | TQ_W | Left wheel commanded torque, signed Nm |
| meas_l_i | input | TQ_W | Left wheel measured torque, signed Nm |
| cmd_r_i | input | TQ_W | Right wheel commanded torque, signed Nm |
| meas_r_i | input | TQ_W | Right wheel measured torque, signed Nm |
| integ_o | output | ACC_W | Accumulated error in Nm·tick |
| fault_o | output | 1 | Latched integral trip |
| wdog_o | output | 1 | Latched strobe stall |
| safe_req_o | output | 1 | Latched active-short-circuit safe-state request |

## Verification
The magnitude and floor logic have no port of their own, so a fault in either shows up at integ_o in the sample right after the strobe edge. A wrong sign, a missing clip or a missing floor gives a value that differs from the bench's own sum at once. A wrong comparison or latch timing appears as fault_o rising one cycle early, one cycle late, or never. A frozen sum that moves anyway appears on the first strobe after the trip. A stall counter that is off by one appears as wdog_o rising a cycle away from the 2*TICK_CYCLES boundary.

// File: rtl/tq_mon_pkg.sv
package tq_mon_pkg;
  localparam int unsigned TQ_W_DEF    = 16;
  localparam int unsigned MAX_ERR_DEF = 5100;
  localparam int unsigned THRESH_PRI  = 25500;
  localparam int unsigned THRESH_SEC  = 45900;
  localparam int unsigned ALLOW_DEF   = 255;
endpackage

// File: rtl/tq_err_mag.sv
module tq_err_mag #(
  parameter int unsigned TQ_W    = 16,
  parameter int unsigned MAX_ERR = 5100,
  parameter int unsigned MAG_W   = $clog2(MAX_ERR + 1)
) (
  input  logic signed [TQ_W-1:0] cmd_l_i,
  input  logic signed [TQ_W-1:0] meas_l_i,
  input  logic signed [TQ_W-1:0] cmd_r_i,
  input  logic signed [TQ_W-1:0] meas_r_i,
  output logic        [MAG_W-1:0] mag_o
);
  localparam int unsigned DW = TQ_W + 2;

  logic signed [DW-1:0] err_l, err_r, diff;
  logic        [DW-1:0] abs_d;

  always_comb begin
    err_l = DW'(cmd_l_i) - DW'(meas_l_i);
    err_r = DW'(cmd_r_i) - DW'(meas_r_i);
    diff  = err_l - err_r;
    abs_d = diff[DW-1] ? DW'(-diff) : DW'(diff);
    if (abs_d > DW'(MAX_ERR)) mag_o = MAG_W'(MAX_ERR);
    else                      mag_o = abs_d[MAG_W-1:0];
  end

  // R1 clip bound
  always_comb begin
    p_mag_clip_r1: assert (mag_o <= MAG_W'(MAX_ERR));
  end
endmodule

// File: rtl/tq_integ.sv
module tq_integ #(
  parameter int unsigned MAX_ERR = 5100,
  parameter int unsigned THRESH  = 25500,
  parameter int unsigned ALLOW   = 255,
  parameter int unsigned MAG_W   = $clog2(MAX_ERR + 1),
  parameter int unsigned ACC_W   = $clog2(THRESH + MAX_ERR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             strobe_i,
  input  logic             hold_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             hit_o
);
  localparam int unsigned SW = ACC_W + 2;

  logic [ACC_W-1:0]    acc_q;
  logic signed [SW-1:0] sum;
  logic                 upd;

  assign hit_o = acc_q >= ACC_W'(THRESH);
  // stop after reaching threshold so the sum stays bounded
  assign upd   = strobe_i && !hold_i && !hit_o;

  always_comb begin
    sum = $signed({2'b00, acc_q}) + $signed(SW'(mag_i)) - $signed(SW'(ALLOW));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clr_i)    acc_q <= '0;
    else if (upd)      acc_q <= sum[SW-1] ? '0 : sum[ACC_W-1:0];
  end

  assign acc_o = acc_q;

  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !clr_i) |=> $stable(acc_q));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q <= ACC_W'(THRESH + MAX_ERR));
endmodule

// File: rtl/tq_stall_wd.sv
module tq_stall_wd #(
  parameter int unsigned TICK_CYCLES = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic strobe_i,
  output logic expire_o
);
  localparam int unsigned LIM   = 2 * TICK_CYCLES;
  localparam int unsigned CNT_W = $clog2(LIM);

  logic [CNT_W-1:0] cnt_q;
  logic             at_lim;

  assign at_lim   = cnt_q == CNT_W'(LIM - 1);
  assign expire_o = at_lim && !strobe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || strobe_i) cnt_q <= '0;
    else if (!at_lim)         cnt_q <= cnt_q + 1'b1;
  end

  p_strobe_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !clr_i) |=> !expire_o || $past(LIM == 1));
endmodule

// File: rtl/torque_err_monitor.sv
module torque_err_monitor
  import tq_mon_pkg::*;
#(
  parameter int unsigned TQ_W        = TQ_W_DEF,
  parameter int unsigned MAX_ERR     = MAX_ERR_DEF,
  parameter int unsigned THRESH      = THRESH_PRI,
  parameter int unsigned ALLOW       = ALLOW_DEF,
  parameter int unsigned TICK_CYCLES = 1000000,
  parameter int unsigned ACC_W       = $clog2(THRESH + MAX_ERR + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   strobe_i,
  input  logic signed [TQ_W-1:0] cmd_l_i,
  input  logic signed [TQ_W-1:0] meas_l_i,
  input  logic signed [TQ_W-1:0] cmd_r_i,
  input  logic signed [TQ_W-1:0] meas_r_i,
  output logic [ACC_W-1:0]       integ_o,
  output logic                   fault_o,
  output logic                   wdog_o,
  output logic                   safe_req_o
);
  localparam int unsigned MAG_W = $clog2(MAX_ERR + 1);

  logic [MAG_W-1:0] mag;
  logic             hit, expire;
  logic             fault_q, wdog_q, safe_q;

  tq_err_mag #(.TQ_W(TQ_W), .MAX_ERR(MAX_ERR), .MAG_W(MAG_W)) u_mag (
    .cmd_l_i (cmd_l_i),
    .meas_l_i(meas_l_i),
    .cmd_r_i (cmd_r_i),
    .meas_r_i(meas_r_i),
    .mag_o   (mag)
  );

  tq_integ #(.MAX_ERR(MAX_ERR), .THRESH(THRESH), .ALLOW(ALLOW),
             .MAG_W(MAG_W), .ACC_W(ACC_W)) u_integ (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .strobe_i(strobe_i),
    .hold_i  (safe_q),
    .mag_i   (mag),
    .acc_o   (integ_o),
    .hit_o   (hit)
  );

  tq_stall_wd #(.TICK_CYCLES(TICK_CYCLES)) u_wd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .strobe_i(strobe_i),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      wdog_q  <= 1'b0;
      safe_q  <= 1'b0;
    end else if (clr_i) begin
      fault_q <= 1'b0;
      wdog_q  <= 1'b0;
      safe_q  <= 1'b0;
    end else begin
      fault_q <= fault_q | hit;
      wdog_q  <= wdog_q | expire;
      safe_q  <= safe_q | hit | expire;
    end
  end

  assign fault_o    = fault_q;
  assign wdog_o     = wdog_q;
  assign safe_req_o = safe_q;

  p_trip_next_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (integ_o >= ACC_W'(THRESH) && !clr_i) |=> (fault_o && safe_req_o));
  p_no_early_trip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(integ_o >= ACC_W'(THRESH)));
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fault_o || wdog_o) && !clr_i) |=> (safe_req_o && $stable(fault_o) && $stable(wdog_o)));
  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (safe_req_o && !clr_i) |=> $stable(integ_o));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (integ_o == '0 && !fault_o && !wdog_o && !safe_req_o));
endmodule

// File: tb/sim_torque_err_monitor.sv
module sim_torque_err_monitor;
  localparam int unsigned TICK = 40;
  localparam int unsigned LIM  = 2 * TICK;
  localparam int unsigned ACC_W = $clog2(25500 + 5100 + 1);

  typedef struct packed {
    logic signed [15:0] cl;
    logic signed [15:0] ml;
    logic signed [15:0] cr;
    logic signed [15:0] mr;
    logic [31:0]        exp_acc;
  } vec_t;

  // R1/R2: expected sums, ALLOW=255, clip 5100
  localparam vec_t VECS [12] = '{
    '{16'sd100,   16'sd100,   16'sd100,   16'sd100,  32'd0},
    '{16'sd1000,  16'sd0,     16'sd0,     16'sd0,    32'd745},
    '{16'sd0,     16'sd0,     16'sd0,     16'sd2000, 32'd2490},
    '{16'sd300,   16'sd0,     16'sd300,   16'sd0,    32'd2235},
    '{16'sd32767, 16'sh8000,  16'sh8000,  16'sd32767,32'd7080},
    '{-16'sd500,  16'sd0,     16'sd500,   16'sd0,    32'd7825},
    '{16'sd0,     16'sd0,     16'sd0,     16'sd0,    32'd7570},
    '{16'sd5100,  16'sd0,     16'sd0,     16'sd0,    32'd12415},
    '{16'sd5101,  16'sd0,     16'sd0,     16'sd0,    32'd17260},
    '{16'sd255,   16'sd0,     16'sd0,     16'sd0,    32'd17260},
    '{16'sd256,   16'sd0,     16'sd0,     16'sd0,    32'd17261},
    '{16'sd0,     16'sd0,     16'sd254,   16'sd0,    32'd17260}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic strobe = 1'b0;
  logic signed [15:0] cl = '0, ml = '0, cr = '0, mr = '0;
  logic [ACC_W-1:0] integ;
  logic fault, wdog, safe_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  torque_err_monitor #(.TICK_CYCLES(TICK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .strobe_i(strobe),
    .cmd_l_i(cl), .meas_l_i(ml), .cmd_r_i(cr), .meas_r_i(mr),
    .integ_o(integ), .fault_o(fault), .wdog_o(wdog), .safe_req_o(safe_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe_once(input logic signed [15:0] a, b, c, d);
    @(negedge clk);
    cl = a; ml = b; cr = c; mr = d;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog run hung actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 integ", 32'(integ), 0);
    chk("R9 fault", 32'(fault), 0);
    chk("R9 wdog", 32'(wdog), 0);
    chk("R9 safe_req", 32'(safe_req), 0);
    rst_n = 1'b1;
    do_clear();

    // R1 R2 table
    for (int i = 0; i < 12; i++) begin
      strobe_once(VECS[i].cl, VECS[i].ml, VECS[i].cr, VECS[i].mr);
      chk($sformatf("R1/R2 vec %0d", i), 32'(integ), VECS[i].exp_acc);
      chk("R4 no early fault", 32'(fault), 0);
    end

    // R2 no strobe -> hold
    cl = 16'sd5000;
    repeat (5) @(negedge clk);
    chk("R2 hold without strobe", 32'(integ), 17260);

    // R4 trip timing
    strobe_once(16'sd5100, 16'sd0, 16'sd0, 16'sd0);
    chk("R2 pre-trip sum", 32'(integ), 22105);
    strobe_once(16'sd5100, 16'sd0, 16'sd0, 16'sd0);
    chk("R3 sum at trip", 32'(integ), 26950);
    chk("R4 fault not yet", 32'(fault), 0);
    chk("R4 safe_req not yet", 32'(safe_req), 0);
    @(negedge clk);
    chk("R4 fault set", 32'(fault), 1);
    chk("R4 safe_req set", 32'(safe_req), 1);

    // R6 frozen
    strobe_once(16'sd5100, 16'sd0, 16'sd0, 16'sd0);
    chk("R6 frozen on strobe", 32'(integ), 26950);
    strobe_once(16'sd0, 16'sd0, 16'sd0, 16'sd0);
    chk("R6 frozen on low error", 32'(integ), 26950);

    // R5 sticky
    repeat (20) @(negedge clk);
    chk("R5 fault sticky", 32'(fault), 1);
    chk("R5 safe_req sticky", 32'(safe_req), 1);

    // R8 clear
    do_clear();
    chk("R8 integ cleared", 32'(integ), 0);
    chk("R8 fault cleared", 32'(fault), 0);
    chk("R8 safe_req cleared", 32'(safe_req), 0);

    // R2 floor at zero
    strobe_once(16'sd100, 16'sd0, 16'sd0, 16'sd0);
    chk("R2 floor", 32'(integ), 0);

    // R7 strobe restarts stall count
    do_clear();
    repeat (LIM - 20) @(negedge clk);
    strobe_once(16'sd0, 16'sd0, 16'sd0, 16'sd0);
    repeat (LIM - 20) @(negedge clk);
    chk("R7 no stall after strobe", 32'(wdog), 0);

    // R7 exact boundary
    do_clear();
    cl = 16'sd0;
    repeat (LIM - 1) @(negedge clk);
    chk("R7 wdog before limit", 32'(wdog), 0);
    chk("R7 safe_req before limit", 32'(safe_req), 0);
    @(negedge clk);
    chk("R7 wdog at limit", 32'(wdog), 1);
    chk("R7 safe_req at limit", 32'(safe_req), 1);
    chk("R7 fault unaffected", 32'(fault), 0);
    repeat (10) @(negedge clk);
    chk("R5 wdog sticky", 32'(wdog), 1);
    do_clear();
    chk("R8 wdog cleared", 32'(wdog), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule